// File: doc/BRIEF.md
# Value Cache Bus Link

This block lowers switching activity on a wide data bus between a cache and external memory. The transmitting half and the receiving half each hold a small table of recently sent words. The table has one slot per bus line. When the sender sees a word that is already in its table, it flips only the bus line whose number matches that slot and raises a hit flag. Any other word is driven onto the bus in raw form with the hit flag low, and both tables store it in the same slot.

The receiving half remembers the last bus value it saw. On a hit it takes the XOR of the new and the remembered value, which must have exactly one bit set. It turns that bit into a slot number and returns the stored word. If the pattern is malformed, or the slot has never been filled, it flags an error. The two halves share one module but connect only through the bus pins. An integrator wires the transmit pins across the physical link to the receive pins of the partner instance. Both tables start empty after reset and fill in the same deterministic order, so they stay identical for as long as the link carries no corruption.

Top module: `vcache_bus_link`

## Requirements
- R1: After reset the transmit bus reads all zeros, no strobe or output valid is raised, and both tables are empty, so the first word sent is a miss.
- R2: A miss drives the raw word on `tx_bus` with `tx_hit` low. `tx_strobe` is high for exactly the one cycle after the word is accepted.
- R3: A hit holds `tx_hit` high. `tx_bus` differs from its previous value in exactly one bit, bit i, where i is the slot that holds the word.
- R4: Misses fill slots 0, 1, 2 and onward in round-robin order, wrapping from slot DW-1 back to slot 0. Each new word overwrites the slot's old value, and the evicted value is a miss when it is sent again.
- R5: On a receive strobe with `rx_hit` low, the next cycle presents `m_data` equal to `rx_bus` with `m_err` low. The word goes into the receiver table at the receiver's round-robin slot.
- R6: On a receive strobe with `rx_hit` high and exactly one changed line i, the next cycle presents the word stored in slot i of the receiver table.
- R7: A receive hit strobe whose changed-line pattern has zero bits or more than one bit set, or that points at an empty slot, raises `m_err` with `m_valid` and drives `m_data` to zero. It leaves the receiver table unchanged.
- R8: `tx_bus` keeps its value in every cycle without a transmit strobe.
- R9: `s_ready` goes high in the first cycle after reset is released and stays high. A word is accepted in every cycle where `s_valid` and `s_ready` are both high.
- R10: `m_valid` is high exactly in the cycle after a receive strobe. With the bus looped back, this is two cycles after the word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Word to send is present |
| s_ready | output | 1 | Sender can accept a word |
| s_data | input | DW | Word to send |
| tx_strobe | output | 1 | Transfer on the bus this cycle |
| tx_hit | output | 1 | Transfer is a single-line toggle |
| tx_bus | output | DW | Transmit bus lines |
| rx_strobe | input | 1 | Incoming transfer this cycle |
| rx_hit | input | 1 | Incoming transfer is a toggle |
| rx_bus | input | DW | Receive bus lines |
| m_valid | output | 1 | Decoded word present |
| m_err | output | 1 | Malformed or unresolvable toggle |
| m_data | output | DW | Decoded word |

## Verification
The bench builds the link with DW set to 8, which gives eight table slots. A few dozen words then fill the table, wrap the replacement pointer several times, and evict words that are later re-sent. A hit on every bus line also comes within reach. Through a small side channel the bench can flip extra lines, cancel the toggle, or force the hit flag between the transmit pins and the receive pins. This reaches the error paths for multi-bit patterns, zero-bit patterns and empty slots.

// File: rtl/vcache_bus_link.sv
module vcache_bus_link #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          tx_strobe,
  output logic          tx_hit,
  output logic [DW-1:0] tx_bus,
  input  logic          rx_strobe,
  input  logic          rx_hit,
  input  logic [DW-1:0] rx_bus,
  output logic          m_valid,
  output logic          m_err,
  output logic [DW-1:0] m_data
);

  localparam int NE = DW;
  localparam int IW = (NE > 1) ? $clog2(NE) : 1;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == IW'(NE - 1)) ? '0 : p + 1'b1;
  endfunction

  // transmit side
  logic [DW-1:0] tx_val [NE];
  logic [NE-1:0] tx_vld;
  logic [IW-1:0] tx_ptr;
  logic [NE-1:0] tx_match;
  logic [IW-1:0] tx_idx;
  logic          rdy_q;
  logic          accept;
  logic          tx_found;

  assign s_ready  = rdy_q;
  assign accept   = s_valid && rdy_q;
  assign tx_found = |tx_match;

  always_comb begin
    for (int i = 0; i < NE; i++) tx_match[i] = tx_vld[i] && (tx_val[i] == s_data);
  end

  always_comb begin
    tx_idx = '0;
    for (int i = NE - 1; i >= 0; i--) if (tx_match[i]) tx_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q     <= 1'b0;
      tx_strobe <= 1'b0;
      tx_hit    <= 1'b0;
      tx_bus    <= '0;
      tx_ptr    <= '0;
      tx_vld    <= '0;
      for (int i = 0; i < NE; i++) tx_val[i] <= '0;
    end else begin
      rdy_q     <= 1'b1;
      tx_strobe <= accept;
      if (accept) begin
        if (tx_found) begin
          tx_hit <= 1'b1;
          tx_bus <= tx_bus ^ (DW'(1) << tx_idx);
        end else begin
          tx_hit         <= 1'b0;
          tx_bus         <= s_data;
          tx_val[tx_ptr] <= s_data;
          tx_vld[tx_ptr] <= 1'b1;
          tx_ptr         <= bump(tx_ptr);
        end
      end
    end
  end

  // receive side
  logic [DW-1:0] rx_val [NE];
  logic [NE-1:0] rx_vld;
  logic [IW-1:0] rx_ptr;
  logic [DW-1:0] rx_prev;
  logic [DW-1:0] diff;
  logic [IW-1:0] rx_idx;
  logic          single;
  logic          bad;

  assign diff   = rx_bus ^ rx_prev;
  assign single = (diff != '0) && ((diff & (diff - 1'b1)) == '0);
  assign bad    = !(single && rx_vld[rx_idx]);

  always_comb begin
    rx_idx = '0;
    for (int i = NE - 1; i >= 0; i--) if (diff[i]) rx_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_err   <= 1'b0;
      m_data  <= '0;
      rx_prev <= '0;
      rx_ptr  <= '0;
      rx_vld  <= '0;
      for (int i = 0; i < NE; i++) rx_val[i] <= '0;
    end else begin
      m_valid <= rx_strobe;
      m_err   <= 1'b0;
      if (rx_strobe) begin
        rx_prev <= rx_bus;
        if (rx_hit) begin
          m_err  <= bad;
          m_data <= bad ? '0 : rx_val[rx_idx];
        end else begin
          m_data         <= rx_bus;
          rx_val[rx_ptr] <= rx_bus;
          rx_vld[rx_ptr] <= 1'b1;
          rx_ptr         <= bump(rx_ptr);
        end
      end
    end
  end

  p_accept_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> tx_strobe);
  p_no_spurious_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !tx_strobe);
  p_miss_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_strobe && !tx_hit) |-> (tx_bus == $past(s_data)));
  p_hit_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_strobe && tx_hit) |-> ($countones(tx_bus ^ $past(tx_bus)) == 1));
  p_bus_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_strobe |-> $stable(tx_bus));
  p_rx_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && !rx_hit) |=> ((m_data == $past(rx_bus)) && !m_err));
  p_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> m_valid);
  p_no_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_strobe |=> !m_valid);
  p_err_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> (m_valid && (m_data == '0)));

endmodule

// File: tb/vcache_bus_link_tb_top.sv
module vcache_bus_link_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         s_valid = 1'b0;
  logic [W-1:0] s_data = '0;
  logic [W-1:0] corrupt_in = '0;
  logic         forcehit_in = 1'b0;
  logic [W-1:0] corrupt_q = '0;
  logic         forcehit_q = 1'b0;
  logic         s_ready, tx_strobe, tx_hit, m_valid, m_err;
  logic [W-1:0] tx_bus, m_data;
  logic [W-1:0] rx_bus;
  logic         rx_hit;

  assign rx_bus = tx_bus ^ corrupt_q;
  assign rx_hit = tx_hit | forcehit_q;

  vcache_bus_link #(.DW(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .tx_strobe(tx_strobe), .tx_hit(tx_hit), .tx_bus(tx_bus),
    .rx_strobe(tx_strobe), .rx_hit(rx_hit), .rx_bus(rx_bus),
    .m_valid(m_valid), .m_err(m_err), .m_data(m_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  int toggles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  logic [W-1:0] mv [W];
  bit           mvld [W];
  int           mptr, hit_j;
  logic [W-1:0] mbus, obs_bus;
  bit           rdy_m;
  bit           pt, pt_hit, pt_err;
  logic [W-1:0] pt_word;
  bit           pr, pr_hit, pr_err;
  logic [W-1:0] pr_data;

  always @(posedge clk) begin
    corrupt_q  <= (s_valid && s_ready) ? corrupt_in : '0;
    forcehit_q <= (s_valid && s_ready) ? forcehit_in : 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < W; i++) begin mvld[i] = 0; mv[i] = '0; end
      mptr = 0; mbus = '0; obs_bus = '0; rdy_m = 0;
      pt = 0; pr = 0; pt_hit = 0; pt_err = 0; pr_err = 0; pr_hit = 0;
    end else begin
      pr = pt; pr_hit = pt_hit || (pt && pt_err); pr_err = pt_err;
      pr_data = pt_err ? '0 : pt_word;
      pt = 0; pt_err = 0;
      if (s_valid && s_ready) begin
        hit_j = -1;
        for (int i = 0; i < W; i++) if (mvld[i] && mv[i] == s_data && hit_j < 0) hit_j = i;
        pt = 1; pt_word = s_data;
        if (hit_j >= 0) begin
          pt_hit = 1; mbus = mbus ^ (W'(1) << hit_j);
          pt_err = (corrupt_in != '0);
        end else begin
          pt_hit = 0; mbus = s_data;
          mv[mptr] = s_data; mvld[mptr] = 1; mptr = (mptr + 1) % W;
          pt_err = forcehit_in;
        end
      end
      rdy_m = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(s_ready == rdy_m, "R9", "s_ready", s_ready, rdy_m);
      chk(tx_strobe == pt, "R2", "tx_strobe", tx_strobe, pt);
      if (pt) begin
        chk(tx_hit == pt_hit, "R4", "hit flag from slot allocation", tx_hit, pt_hit);
        if (pt_hit) begin
          chk(tx_bus == mbus, "R3", "toggled bus", tx_bus, mbus);
          chk($countones(tx_bus ^ obs_bus) == 1, "R3", "lines toggled",
              $countones(tx_bus ^ obs_bus), 1);
        end else begin
          chk(tx_bus == mbus, "R2", "raw bus", tx_bus, mbus);
        end
        toggles += $countones(tx_bus ^ obs_bus);
        obs_bus = tx_bus;
      end else begin
        chk(tx_bus == mbus, "R8", "idle bus hold", tx_bus, mbus);
      end
      chk(m_valid == pr, "R10", "m_valid timing", m_valid, pr);
      if (pr) begin
        if (pr_err) begin
          chk(m_err == 1'b1, "R7", "m_err", m_err, 1);
          chk(m_data == '0, "R7", "m_data on error", m_data, 0);
        end else if (pr_hit) begin
          chk(!m_err && m_data == pr_data, "R6", "decoded hit word", {m_err, m_data}, pr_data);
        end else begin
          chk(!m_err && m_data == pr_data, "R5", "decoded miss word", {m_err, m_data}, pr_data);
        end
      end
    end
  end

  task automatic send(input logic [W-1:0] d, input logic [W-1:0] cm = '0, input bit fh = 0);
    @(negedge clk);
    s_valid = 1'b1; s_data = d; corrupt_in = cm; forcehit_in = fh;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      s_valid = 1'b0; corrupt_in = '0; forcehit_in = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    s_valid = 1'b0; corrupt_in = '0; forcehit_in = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_bus == '0, "R1", "bus in reset", tx_bus, 0);
    chk(!tx_strobe && !m_valid, "R1", "strobes in reset", {tx_strobe, m_valid}, 0);
    rst_n = 1'b1;
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit [31:0] seed = 32'h1234_5678;
    do_reset();
    chk(s_ready == 1'b1, "R9", "ready after reset", s_ready, 1);
    // R7: forced hit aimed at a slot the receiver never filled
    send(8'h04, '0, 1);
    idle(3);
    do_reset();

    for (int k = 0; k < W; k++) send(8'h10 + 8'(k));
    idle(2);
    send(8'h15); send(8'h12); send(8'h17); send(8'h10); send(8'h13);
    idle(1);
    send(8'h12); send(8'h12);
    send(8'h99);
    send(8'h10);
    send(8'h12);
    idle(2);
    // R7: extra line flipped, then zero-line pattern, each followed by a fresh miss
    send(8'h12, 8'h40);
    send(8'hE1);
    send(8'hE1, 8'h04);
    send(8'hE2);
    idle(2);

    for (int k = 0; k < 400; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      if (seed[20:18] < 3'd5) send(8'h40 + 8'(seed[27:24] % 12));
      else idle(1);
    end
    idle(4);
    $display("bus toggles counted: %0d", toggles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule